// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the register front end for the channels of a descriptor-driven DMA controller. A 32-bit bus reaches it through a single request port. The upper address bits choose a channel, and each channel owns a 0x2000-byte window. Bits [7:2] of the address choose a register inside that window. Each channel holds five descriptor pointers and a configuration word, a command word, a stream-command word and an interrupt mask. It also holds a sticky raw-interrupt vector and a one-hot run state.

The data engine sits beside the block. It drives raw interrupt-set pulses into the block, and it also drives a reached-end-of-list flag, the end-of-list bit of the current descriptor and a stream-command source code. In return the block gives the engine single-cycle strobes for start, continue, load-data-descriptor and load-context. It also drives one level interrupt per channel. The block does not fetch descriptors and does not move data.

Top module: `dmareg_front`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, every channel's state is reset (status bits [2:0] = 1), and every interrupt line is low.
- R2: The channel is `req_addr[ADDR_W-1:13]` and the register index is `req_addr[7:2]`. Address bits [12:8] are ignored, so offsets alias inside a window. A channel number of NUM_CH or more reads zero and ignores writes. Unmapped offsets read zero and ignore writes.
- R3: The pointer registers at byte offsets 0x00, 0x58, 0x5C, 0x60 and 0x7C store and read back all 32 written bits, separately for each channel.
- R4: Configuration (0x84) keeps bits [1:0]. Bit 0 is enable and bit 1 is stop. A write with bit 0 clear sets the state to reset (1). Otherwise a write with bit 1 set sets the state to stopped (2). Any other write leaves the state unchanged.
- R5: Status (0x88) reads the state at [2:0] (reset 1, stopped 2, running 4), the engine's end-of-list flag at bit 5 and the source code at [8+SRC_W-1:8]. All other bits read zero, and writes to status are ignored.
- R6: Stream command (0x9C) keeps the low 10 bits. If a written value ANDed with 0x140 is non-zero, a load-data strobe follows. If bit 0x20 is also set, a start strobe follows and the state becomes running. If bit 0x200 is set, a load-context strobe follows.
- R7: Command (0x80) keeps bit 0. Every write to it raises the continue strobe, but only when enable is 1, stop is 0, the state is running and the engine's descriptor end-of-list input is high.
- R8: Raw interrupt (0x94) ORs in each set pulse from the engine. The bits stay set until they are acknowledged, and writes to this register are ignored.
- R9: Acknowledge (0x90) clears every raw bit that is written as one. If a set pulse arrives in the same cycle, the set wins. Acknowledge always reads zero.
- R10: Mask is at 0x8C. Masked interrupt (0x98) reads raw AND mask. A channel's interrupt line is high exactly when its masked value is non-zero, and it reflects the state after the most recent clock edge.
- R11: An access whose size code is not 2 (32-bit) pulses `acc_err` in the next cycle. It returns no read data and changes no state.
- R12: A read returns `rd_valid` and `rd_data` in the cycle after the request. Every strobe is one cycle long and appears in the cycle after the write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 invalid |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Access size error pulse |
| eng_irq_set | input | NUM_CH*IRQ_W | Raw interrupt-set pulses, IRQ_W bits per channel |
| eng_eol | input | NUM_CH | Engine has reached end of list, per channel |
| eng_desc_eol | input | NUM_CH | Current data descriptor has its end-of-list bit set |
| eng_src | input | NUM_CH*SRC_W | Stream-command source code per channel |
| irq | output | NUM_CH | Level interrupt per channel |
| start_strb | output | NUM_CH | Start strobe |
| cont_strb | output | NUM_CH | Continue strobe |
| load_d_strb | output | NUM_CH | Load-data-descriptor strobe |
| load_c_strb | output | NUM_CH | Load-context strobe |

## Verification
A wrong channel state shows up in the status word on the first status read after the fault. It also shows up as a missing or extra continue strobe, one cycle after the next command write. A wrong raw or mask bit reaches the interrupt line in the cycle after the faulty edge, so the bench's per-clock comparison against its own register model catches it at once. Decode faults, such as a wrong channel, offset aliasing, size rejection or an out-of-range channel, corrupt the next read-back of that channel's registers. The bench therefore reads every written register back and also reads the registers it did not write.

// File: rtl/dmareg_pkg.sv
// Package: shared register indices, channel state encoding and stream-command
// bit meanings for the DMA channel register front end.
package dmareg_pkg;
    localparam int REG_IDX_W = 6;
    localparam int PTR_N     = 5;

    // Word indices (byte offset / 4) inside a channel window.
    localparam logic [REG_IDX_W-1:0] IX_DATA    = 6'h00;
    localparam logic [REG_IDX_W-1:0] IX_SAVED   = 6'h16;
    localparam logic [REG_IDX_W-1:0] IX_SAVEDB  = 6'h17;
    localparam logic [REG_IDX_W-1:0] IX_GROUP   = 6'h18;
    localparam logic [REG_IDX_W-1:0] IX_GROUPDN = 6'h1F;
    localparam logic [REG_IDX_W-1:0] IX_CMD     = 6'h20;
    localparam logic [REG_IDX_W-1:0] IX_CFG     = 6'h21;
    localparam logic [REG_IDX_W-1:0] IX_STAT    = 6'h22;
    localparam logic [REG_IDX_W-1:0] IX_MASK    = 6'h23;
    localparam logic [REG_IDX_W-1:0] IX_ACK     = 6'h24;
    localparam logic [REG_IDX_W-1:0] IX_RAW     = 6'h25;
    localparam logic [REG_IDX_W-1:0] IX_MASKED  = 6'h26;
    localparam logic [REG_IDX_W-1:0] IX_SCMD    = 6'h27;

    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [9:0] SC_LOAD_D = 10'h140;
    localparam logic [9:0] SC_BURST  = 10'h020;
    localparam logic [9:0] SC_LOAD_C = 10'h200;

    typedef enum logic [2:0] {
        CH_RESET   = 3'b001,
        CH_STOPPED = 3'b010,
        CH_RUNNING = 3'b100
    } ch_state_e;

    // Maps a pointer slot number to its register index.
    function automatic logic [REG_IDX_W-1:0] ptr_ix(input int slot);
        case (slot)
            0:       return IX_DATA;
            1:       return IX_SAVED;
            2:       return IX_SAVEDB;
            3:       return IX_GROUP;
            default: return IX_GROUPDN;
        endcase
    endfunction
endpackage

// File: rtl/dmareg_decode.sv
// Module: dmareg_decode
// Splits a bus request into a one-hot channel hit, a register index and
// read/write/error qualifiers. Assumes at most one request per cycle and that
// only 32-bit accesses are legal; channel numbers >= NUM_CH hit nothing.
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    output logic [NUM_CH-1:0]    ch_hit,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic                 wr_go,
    output logic                 rd_go,
    output logic                 err_go
);
    localparam int CH_W = ADDR_W - 13;

    logic            word_ok;
    logic [CH_W-1:0] ch_field;
    logic            unused_addr;

    assign word_ok     = (req_size == SZ_WORD);
    assign ch_field    = req_addr[ADDR_W-1:13];
    assign reg_idx     = req_addr[7:2];
    assign unused_addr = ^{req_addr[12:8], req_addr[1:0]};

    assign wr_go  = req_valid &&  req_write && word_ok;
    assign rd_go  = req_valid && !req_write && word_ok;
    assign err_go = req_valid && !word_ok;

    // Channel selection: one bit per implemented channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign ch_hit[c] = req_valid && word_ok && (ch_field == CH_W'(c));
    end

    // R2
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_hit));

    // R11
    err_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_go |-> !(wr_go || rd_go));
endmodule

// File: rtl/dmareg_chan.sv
// Module: dmareg_chan
// One channel's registers: descriptor pointers, configuration, command,
// stream command, interrupt mask and raw interrupts, plus the one-hot run
// state and the engine strobes. Assumes wr_go is already qualified by the
// channel hit and the word size; rdata is combinational for reg_idx.
module dmareg_chan
    import dmareg_pkg::*;
#(
    parameter int IRQ_W = 4,
    parameter int SRC_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_go,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [31:0]          wdata,
    input  logic [IRQ_W-1:0]     irq_set,
    input  logic                 eng_eol,
    input  logic                 desc_eol,
    input  logic [SRC_W-1:0]     eng_src,
    output logic [31:0]          rdata,
    output logic                 irq,
    output logic                 start_o,
    output logic                 cont_o,
    output logic                 load_d_o,
    output logic                 load_c_o
);
    logic [PTR_N-1:0][31:0] ptr_q;
    logic [1:0]             cfg_q;
    logic                   cmd_q;
    logic [9:0]             scmd_q;
    logic [IRQ_W-1:0]       mask_q;
    logic [IRQ_W-1:0]       raw_q;
    ch_state_e              state_q;

    logic wr_cfg, wr_cmd, wr_scmd, wr_mask, wr_ack;
    logic sc_load_d, sc_start, sc_load_c, cont_ok;
    logic [IRQ_W-1:0] ack_bits;
    logic [31:0]      stat_word;

    assign wr_cfg  = wr_go && (reg_idx == IX_CFG);
    assign wr_cmd  = wr_go && (reg_idx == IX_CMD);
    assign wr_scmd = wr_go && (reg_idx == IX_SCMD);
    assign wr_mask = wr_go && (reg_idx == IX_MASK);
    assign wr_ack  = wr_go && (reg_idx == IX_ACK);

    assign sc_load_d = wr_scmd && |(wdata[9:0] & SC_LOAD_D);
    assign sc_start  = sc_load_d && |(wdata[9:0] & SC_BURST);
    assign sc_load_c = wr_scmd && |(wdata[9:0] & SC_LOAD_C);
    assign cont_ok   = wr_cmd && cfg_q[0] && !cfg_q[1]
                       && (state_q == CH_RUNNING) && desc_eol;
    assign ack_bits  = wr_ack ? wdata[IRQ_W-1:0] : '0;

    // Descriptor pointer storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            for (int p = 0; p < PTR_N; p++) begin
                if (wr_go && reg_idx == ptr_ix(p)) ptr_q[p] <= wdata;
            end
        end
    end

    // Control words: configuration, command, stream command, mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cmd_q  <= 1'b0;
            scmd_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_cfg)  cfg_q  <= wdata[1:0];
            if (wr_cmd)  cmd_q  <= wdata[0];
            if (wr_scmd) scmd_q <= wdata[9:0];
            if (wr_mask) mask_q <= wdata[IRQ_W-1:0];
        end
    end

    // Run state: configuration writes force reset or stopped, start runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_RESET;
        end else if (wr_cfg) begin
            if (!wdata[0])     state_q <= CH_RESET;
            else if (wdata[1]) state_q <= CH_STOPPED;
        end else if (sc_start) begin
            state_q <= CH_RUNNING;
        end
    end

    // Sticky raw interrupts: acknowledge clears, engine set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~ack_bits) | irq_set;
    end

    // One-cycle strobes toward the data engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o  <= 1'b0;
            cont_o   <= 1'b0;
            load_d_o <= 1'b0;
            load_c_o <= 1'b0;
        end else begin
            start_o  <= sc_start;
            cont_o   <= cont_ok;
            load_d_o <= sc_load_d;
            load_c_o <= sc_load_c;
        end
    end

    assign irq = |(raw_q & mask_q);

    // Status word assembly.
    always_comb begin
        stat_word = '0;
        stat_word[2:0] = state_q;
        stat_word[5] = eng_eol;
        stat_word[8 +: SRC_W] = eng_src;
    end

    // Read multiplexer for the addressed register.
    always_comb begin
        rdata = '0;
        case (reg_idx)
            IX_CMD:    rdata[0] = cmd_q;
            IX_CFG:    rdata[1:0] = cfg_q;
            IX_STAT:   rdata = stat_word;
            IX_MASK:   rdata[IRQ_W-1:0] = mask_q;
            IX_RAW:    rdata[IRQ_W-1:0] = raw_q;
            IX_MASKED: rdata[IRQ_W-1:0] = raw_q & mask_q;
            IX_SCMD:   rdata[9:0] = scmd_q;
            default: begin
                for (int p = 0; p < PTR_N; p++) begin
                    if (reg_idx == ptr_ix(p)) rdata = ptr_q[p];
                end
            end
        endcase
    end

    // R5
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    // R4
    cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !wdata[0]) |=> (state_q == CH_RESET));

    // R6
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (state_q == CH_RUNNING) && load_d_o);

    // R7
    cont_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cont_o |-> ($past(state_q) == CH_RUNNING) && $past(desc_eol));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> ((raw_q & $past(wdata[IRQ_W-1:0]) & ~$past(irq_set)) == '0));
endmodule

// File: rtl/dmareg_front.sv
// Module: dmareg_front (top)
// Register front end for NUM_CH DMA channels: decodes 32-bit bus accesses,
// instantiates one register channel per DMA channel and registers the read
// data and the size-error pulse. Assumes a single-cycle request protocol.
module dmareg_front
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 16,
    parameter int IRQ_W  = 4,
    parameter int SRC_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [31:0]             req_wdata,
    output logic                    rd_valid,
    output logic [31:0]             rd_data,
    output logic                    acc_err,
    input  logic [NUM_CH*IRQ_W-1:0] eng_irq_set,
    input  logic [NUM_CH-1:0]       eng_eol,
    input  logic [NUM_CH-1:0]       eng_desc_eol,
    input  logic [NUM_CH*SRC_W-1:0] eng_src,
    output logic [NUM_CH-1:0]       irq,
    output logic [NUM_CH-1:0]       start_strb,
    output logic [NUM_CH-1:0]       cont_strb,
    output logic [NUM_CH-1:0]       load_d_strb,
    output logic [NUM_CH-1:0]       load_c_strb
);
    logic [NUM_CH-1:0]    ch_hit;
    logic [REG_IDX_W-1:0] reg_idx;
    logic                 wr_go, rd_go, err_go;
    logic [31:0]          ch_rdata [NUM_CH];
    logic [31:0]          rd_mux;

    dmareg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .ch_hit    (ch_hit),
        .reg_idx   (reg_idx),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .err_go    (err_go)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmareg_chan #(.IRQ_W(IRQ_W), .SRC_W(SRC_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_go    (wr_go && ch_hit[c]),
            .reg_idx  (reg_idx),
            .wdata    (req_wdata),
            .irq_set  (eng_irq_set[c*IRQ_W +: IRQ_W]),
            .eng_eol  (eng_eol[c]),
            .desc_eol (eng_desc_eol[c]),
            .eng_src  (eng_src[c*SRC_W +: SRC_W]),
            .rdata    (ch_rdata[c]),
            .irq      (irq[c]),
            .start_o  (start_strb[c]),
            .cont_o   (cont_strb[c]),
            .load_d_o (load_d_strb[c]),
            .load_c_o (load_c_strb[c])
        );
    end

    // Select the hit channel's read word; no hit reads zero.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) rd_mux = rd_mux | ch_rdata[c];
        end
    end

    // Registered read response and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            rd_data  <= rd_go ? rd_mux : '0;
            acc_err  <= err_go;
        end
    end

    // R11
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> !rd_valid);

    // R12
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
endmodule

// File: tb/dmareg_front_tb.sv
// Bench: behavioural register model updated on every rising edge and compared
// against all outputs on every falling edge.
module dmareg_front_tb;
    localparam int NC = 2;
    localparam int AW = 16;
    localparam int IW = 4;
    localparam int SW = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic rd_valid, acc_err;
    logic [31:0] rd_data;
    logic [NC*IW-1:0] eng_irq_set = '0;
    logic [NC-1:0] eng_eol = '0, eng_desc_eol = '0;
    logic [NC*SW-1:0] eng_src = '0;
    logic [NC-1:0] irq, start_strb, cont_strb, load_d_strb, load_c_strb;

    always #5 clk = ~clk;

    dmareg_front #(.NUM_CH(NC), .ADDR_W(AW), .IRQ_W(IW), .SRC_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .eng_irq_set(eng_irq_set), .eng_eol(eng_eol), .eng_desc_eol(eng_desc_eol),
        .eng_src(eng_src), .irq(irq), .start_strb(start_strb), .cont_strb(cont_strb),
        .load_d_strb(load_d_strb), .load_c_strb(load_c_strb)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural model state.
    logic [31:0] m_ptr [NC][5];
    logic [1:0]  m_cfg [NC];
    logic        m_cmd [NC];
    logic [9:0]  m_scmd [NC];
    logic [3:0]  m_mask [NC], m_raw [NC];
    logic [2:0]  m_state [NC];
    logic        m_rdv, m_err;
    logic [31:0] m_rdd;
    logic [NC-1:0] m_start, m_cont, m_ld, m_lc;

    function automatic int ptr_slot(int off);
        case (off)
            'h00: return 0;
            'h58: return 1;
            'h5C: return 2;
            'h60: return 3;
            'h7C: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] mread(int c, int off);
        int s = ptr_slot(off);
        if (s >= 0) return m_ptr[c][s];
        case (off)
            'h80: return {31'b0, m_cmd[c]};
            'h84: return {30'b0, m_cfg[c]};
            'h88: return {20'b0, eng_src[c*SW +: SW], 2'b0, eng_eol[c], 2'b0, m_state[c]};
            'h8C: return {28'b0, m_mask[c]};
            'h94: return {28'b0, m_raw[c]};
            'h98: return {28'b0, m_raw[c] & m_mask[c]};
            'h9C: return {22'b0, m_scmd[c]};
            default: return 32'b0;
        endcase
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        int ch, off, s;
        logic [3:0] ack [NC];
        for (int c = 0; c < NC; c++) ack[c] = 4'b0;
        m_rdv = 0; m_err = 0; m_rdd = 0;
        m_start = 0; m_cont = 0; m_ld = 0; m_lc = 0;
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                for (int p = 0; p < 5; p++) m_ptr[c][p] = 0;
                m_cfg[c] = 0; m_cmd[c] = 0; m_scmd[c] = 0;
                m_mask[c] = 0; m_raw[c] = 0; m_state[c] = 3'd1;
            end
        end else begin
            ch = int'(req_addr >> 13);
            off = int'({req_addr[7:2], 2'b00});
            if (req_valid) begin
                if (req_size != 2'd2) m_err = 1;
                else if (!req_write) begin
                    m_rdv = 1;
                    m_rdd = (ch < NC) ? mread(ch, off) : 32'b0;
                end else if (ch < NC) begin
                    s = ptr_slot(off);
                    if (s >= 0) m_ptr[ch][s] = req_wdata;
                    case (off)
                        'h80: begin
                            m_cmd[ch] = req_wdata[0];
                            m_cont[ch] = (m_cfg[ch] == 2'b01) && (m_state[ch] == 3'd4)
                                         && eng_desc_eol[ch];
                        end
                        'h84: begin
                            m_cfg[ch] = req_wdata[1:0];
                            if (!req_wdata[0]) m_state[ch] = 3'd1;
                            else if (req_wdata[1]) m_state[ch] = 3'd2;
                        end
                        'h8C: m_mask[ch] = req_wdata[3:0];
                        'h90: ack[ch] = req_wdata[3:0];
                        'h9C: begin
                            m_scmd[ch] = req_wdata[9:0];
                            m_ld[ch] = (req_wdata[9:0] & 10'h140) != 0;
                            m_start[ch] = m_ld[ch] && req_wdata[5];
                            m_lc[ch] = req_wdata[9];
                            if (m_start[ch]) m_state[ch] = 3'd4;
                        end
                        default: ;
                    endcase
                end
            end
            for (int c = 0; c < NC; c++)
                m_raw[c] = (m_raw[c] & ~ack[c]) | eng_irq_set[c*IW +: IW];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", req, what, got, exp);
        end
    endtask

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NC-1:0] m_irq;
            for (int c = 0; c < NC; c++) m_irq[c] = |(m_raw[c] & m_mask[c]);
            chk(rd_valid === m_rdv, "R12", "rd_valid", {31'b0, rd_valid}, {31'b0, m_rdv});
            if (m_rdv) chk(rd_data === m_rdd, cur_req, "rd_data", rd_data, m_rdd);
            chk(acc_err === m_err, "R11", "acc_err", {31'b0, acc_err}, {31'b0, m_err});
            chk(irq === m_irq, "R10", "irq", {30'b0, irq}, {30'b0, m_irq});
            chk(start_strb === m_start, "R6", "start", {30'b0, start_strb}, {30'b0, m_start});
            chk(load_d_strb === m_ld, "R6", "load_d", {30'b0, load_d_strb}, {30'b0, m_ld});
            chk(load_c_strb === m_lc, "R6", "load_c", {30'b0, load_c_strb}, {30'b0, m_lc});
            chk(cont_strb === m_cont, "R7", "cont", {30'b0, cont_strb}, {30'b0, m_cont});
        end
    end

    task automatic acc(input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [1:0] sz = 2'd2);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_size = 2'd2;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        acc(1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        acc(0, a, 32'h0);
        @(negedge clk);
    endtask

    localparam logic [AW-1:0] C1 = 16'h2000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // r1_ reset state
        cur_req = "R1";
        rd(16'h0088); rd(C1 + 16'h0088); rd(16'h0058); rd(16'h0094); rd(16'h0084);
        // R3 pointers
        cur_req = "R3";
        wr(16'h0000, 32'hA5A5_0001); wr(16'h0058, 32'h1234_5678); wr(16'h005C, 32'hFFFF_0000);
        wr(16'h0060, 32'h0BAD_F00D); wr(16'h007C, 32'hDEAD_BEEF); wr(C1 + 16'h0058, 32'h5555_AAAA);
        rd(16'h0000); rd(16'h0058); rd(16'h005C); rd(16'h0060); rd(16'h007C);
        rd(C1 + 16'h0058); rd(C1 + 16'h0000);
        // R2 decode: aliasing, out-of-range channel, unmapped offset
        cur_req = "R2";
        rd(16'h1F58); wr(16'h4058, 32'h7777_7777); rd(16'h4058); rd(16'h0058);
        wr(16'h0040, 32'hFFFF_FFFF); rd(16'h0040); rd(C1 + 16'h005C);
        // R4 configuration and state forcing
        cur_req = "R4";
        wr(16'h0084, 32'h3); rd(16'h0088); wr(16'h0084, 32'h1); rd(16'h0088); rd(16'h0084);
        wr(16'h0084, 32'h2); rd(16'h0088); wr(16'h0084, 32'hFFFF_FFFC); rd(16'h0084);
        // R6 stream commands
        cur_req = "R6";
        wr(16'h0084, 32'h1);
        wr(16'h009C, 32'h160); rd(16'h0088); wr(16'h009C, 32'h040); wr(16'h009C, 32'h100);
        wr(16'h009C, 32'h200); wr(C1 + 16'h009C, 32'hFFFF_FFFF); rd(C1 + 16'h009C);
        rd(C1 + 16'h0088);
        // R7 continue gating
        cur_req = "R7";
        eng_desc_eol = 2'b01;
        wr(16'h0080, 32'h1); rd(16'h0080);
        eng_desc_eol = 2'b00; wr(16'h0080, 32'h0);
        eng_desc_eol = 2'b11; wr(C1 + 16'h0080, 32'h1);
        wr(16'h0084, 32'h3); wr(16'h0080, 32'h1);
        wr(16'h0084, 32'h1); wr(16'h0080, 32'h1);
        wr(16'h009C, 32'h160); wr(16'h0080, 32'h1); eng_desc_eol = 2'b00;
        // R5 status fields
        cur_req = "R5";
        eng_eol = 2'b10; eng_src = 8'h5A;
        rd(16'h0088); rd(C1 + 16'h0088); wr(16'h0088, 32'hFFFF_FFFF); rd(16'h0088);
        // R8 raw interrupts
        cur_req = "R8";
        eng_irq_set = 8'h05; @(negedge clk); eng_irq_set = 0;
        rd(16'h0094); wr(16'h0094, 32'h0); rd(16'h0094);
        eng_irq_set = 8'h30; @(negedge clk); eng_irq_set = 0;
        rd(C1 + 16'h0094);
        // R10 mask and masked view
        cur_req = "R10";
        wr(16'h008C, 32'h4); rd(16'h0098); wr(C1 + 16'h008C, 32'h8); rd(C1 + 16'h0098);
        wr(C1 + 16'h008C, 32'hF); rd(C1 + 16'h0098);
        // R9 acknowledge
        cur_req = "R9";
        wr(16'h0090, 32'h4); rd(16'h0094); rd(16'h0090);
        eng_irq_set = 8'h02; wr(16'h0090, 32'h3); eng_irq_set = 0;
        rd(16'h0094); wr(C1 + 16'h0090, 32'hF); rd(C1 + 16'h0094);
        // R11 size errors have no effect
        cur_req = "R11";
        acc(1, 16'h0058, 32'h0, 2'd0); acc(0, 16'h0058, 32'h0, 2'd1);
        acc(1, 16'h009C, 32'h160, 2'd3); acc(1, 16'h0084, 32'h0, 2'd1);
        rd(16'h0058); rd(16'h0088);
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule